// File: doc/BRIEF.md
# Fixed-Sequence Modulo Counter

This block is a 4-bit synchronous up-counter whose three fixed count sequences all wrap in the same way. At the end of each sequence the block loads a constant through its synchronous parallel-load path, rather than clearing the register. A static two-bit mode input picks one of three sequences: a decimal counter (0 to 9), a divide-by-seven counter (0 to 6), or an offset six-state counter (9 to 14).

The next state comes from an incrementer built as a serial gating chain. Bit i toggles when count enable is high and every lower bit is 1. The load path takes priority over counting. Reset uses the same load path, so reset is synchronous and presets the register to the first state of the selected sequence.

The end-of-sequence decode looks at only two bits of the count. States that cannot be reached are treated as don't-cares. A terminal-count flag marks the last state of the sequence. A carry output is kept from the raw 4-bit incrementer so that stages can be chained.

Top module: `modctr_set`

## Requirements
- R1: While `rst` is high, each rising clock edge sets `count` to the first state of the selected mode: 0 for mode codes 0, 1 and 3, and 9 for mode code 2.
- R2: In mode code 0 (decimal), with `cnt_en` held high, `count` steps 0,1,2,...,9 and then returns to 0.
- R3: In mode code 1 (divide-by-seven), with `cnt_en` held high, `count` steps 0,1,...,6 and then returns to 0.
- R4: In mode code 2 (offset), with `cnt_en` held high, `count` steps 9,10,11,12,13,14 and then returns to 9.
- R5: When `cnt_en` is low and `rst` is low, `count` keeps its value over the clock edge. This includes the terminal state, where no wrap takes place.
- R6: `term_cnt` is high exactly when `cnt_en` is high and `count` is in the last state of the selected sequence: 9 in mode 0, 6 in mode 1, 14 in mode 2.
- R7: `carry_out` is high only when `count` is 15 and `cnt_en` is high. It therefore stays low throughout every reachable sequence.
- R8: Mode code 3 behaves exactly like mode code 0.
- R9: `rst` overrides `cnt_en`. A reset edge with `cnt_en` high still gives the preset value, whether or not `count` is at the terminal state.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock shared by all state bits |
| rst | input | 1 | Synchronous active-high reset to the first state of the mode |
| cnt_en | input | 1 | Count enable; when low, the count holds |
| mode | input | 2 | Sequence select: 0 decimal, 1 divide-by-seven, 2 offset 9..14, 3 same as 0 |
| count | output | 4 | Current count value |
| term_cnt | output | 1 | High in the last state of the sequence while counting is enabled |
| carry_out | output | 1 | High when all four count bits are 1 and counting is enabled |

## Verification
A broken toggle term or a wrong load constant shows on `count` at the clock edge after the faulty state is entered. The sequence then either skips a value or leaves the legal range, and comparing against a per-cycle model catches it within one cycle. A decode fault surfaces in two ways. `term_cnt` is wrong in the same cycle, because it is combinational from `count`. The missed or early wrap then shows on `count` one edge later. A fault in the enable gating shows as a changed count during a hold cycle.

// File: rtl/modctr_pkg.sv
package modctr_pkg;

    localparam int CNT_W = 4;

    typedef logic [CNT_W-1:0] cnt_t;

    typedef enum logic [1:0] {
        SEQ_DEC  = 2'd0,
        SEQ_SEV  = 2'd1,
        SEQ_OFS  = 2'd2,
        SEQ_ALT  = 2'd3
    } seq_t;

    typedef struct packed {
        logic load;
        cnt_t data;
        logic term;
    } wrap_ctl_t;

    localparam cnt_t DEC_FIRST = 4'd0;
    localparam cnt_t DEC_LAST  = 4'd9;
    localparam cnt_t SEV_FIRST = 4'd0;
    localparam cnt_t SEV_LAST  = 4'd6;
    localparam cnt_t OFS_FIRST = 4'd9;
    localparam cnt_t OFS_LAST  = 4'd14;

    function automatic cnt_t seq_first(input seq_t s);
        case (s)
            SEQ_SEV: return SEV_FIRST;
            SEQ_OFS: return OFS_FIRST;
            default: return DEC_FIRST;
        endcase
    endfunction

    function automatic cnt_t seq_last(input seq_t s);
        case (s)
            SEQ_SEV: return SEV_LAST;
            SEQ_OFS: return OFS_LAST;
            default: return DEC_LAST;
        endcase
    endfunction

    // Two-bit end-of-sequence decode; unreachable codes are don't-cares.
    function automatic logic seq_end(input seq_t s, input cnt_t q);
        case (s)
            SEQ_SEV: return q[2] & q[1];
            SEQ_OFS: return q[2] & q[1];
            default: return q[3] & q[0];
        endcase
    endfunction

endpackage

// File: rtl/modctr_core.sv
module modctr_core #(
    parameter int W = 4
) (
    input  logic         clk,
    input  logic         load,
    input  logic         cnt_en,
    input  logic [W-1:0] ld_data,
    output logic [W-1:0] q,
    output logic         carry
);
    logic [W-1:0] tog;

    // Serial gating chain: bit i flips when enable and all lower bits are 1.
    genvar i;
    generate
        for (i = 0; i < W; i++) begin : g_tog
            if (i == 0) begin : g_lsb
                assign tog[i] = cnt_en;
            end else begin : g_up
                assign tog[i] = tog[i-1] & q[i-1];
            end
        end
    endgenerate

    assign carry = tog[W-1] & q[W-1];

    always_ff @(posedge clk) begin
        if (load) begin
            q <= ld_data;
        end else begin
            q <= q ^ tog;
        end
    end
endmodule

// File: rtl/modctr_wrap_ctl.sv
module modctr_wrap_ctl
    import modctr_pkg::*;
(
    input  logic      rst,
    input  logic      cnt_en,
    input  seq_t      seq,
    input  cnt_t      q,
    output wrap_ctl_t ctl
);
    logic at_end;

    always_comb begin
        at_end   = seq_end(seq, q);
        ctl.term = at_end & cnt_en;
        ctl.load = rst | ctl.term;
        ctl.data = seq_first(seq);
    end
endmodule

// File: rtl/modctr_set.sv
module modctr_set
    import modctr_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             cnt_en,
    input  logic [1:0]       mode,
    output logic [CNT_W-1:0] count,
    output logic             term_cnt,
    output logic             carry_out
);
    seq_t      seq;
    wrap_ctl_t ctl;
    cnt_t      q;
    logic      carry;

    assign seq = seq_t'(mode);

    modctr_wrap_ctl u_ctl (
        .rst    (rst),
        .cnt_en (cnt_en),
        .seq    (seq),
        .q      (q),
        .ctl    (ctl)
    );

    modctr_core #(.W(CNT_W)) u_core (
        .clk     (clk),
        .load    (ctl.load),
        .cnt_en  (cnt_en),
        .ld_data (ctl.data),
        .q       (q),
        .carry   (carry)
    );

    assign count     = q;
    assign term_cnt  = ctl.term;
    assign carry_out = carry;
endmodule

// File: rtl/modctr_set_chk.sv
module modctr_set_chk
    import modctr_pkg::*;
(
    input logic             clk,
    input logic             rst,
    input logic             cnt_en,
    input logic [1:0]       mode,
    input logic [CNT_W-1:0] count,
    input logic             term_cnt,
    input logic             carry_out
);
    AST_RESET_PRESET: assert property (@(posedge clk)
        rst |=> count == seq_first(seq_t'($past(mode))));  // R1

    AST_HOLD: assert property (@(posedge clk) disable iff (rst)
        !cnt_en |=> $stable(count));  // R5

    AST_STEP: assert property (@(posedge clk) disable iff (rst)
        (cnt_en && !term_cnt) |=> count == 4'($past(count) + 4'd1));  // R2

    AST_WRAP: assert property (@(posedge clk) disable iff (rst)
        term_cnt |=> count == seq_first(seq_t'(mode)));  // R4

    AST_TERM_LAST: assert property (@(posedge clk) disable iff (rst)
        term_cnt == (cnt_en && count == seq_last(seq_t'(mode))));  // R6

    AST_CARRY: assert property (@(posedge clk) disable iff (rst)
        carry_out |-> (cnt_en && count == 4'hF));  // R7

    AST_IN_RANGE: assert property (@(posedge clk) disable iff (rst)
        (count >= seq_first(seq_t'(mode))) && (count <= seq_last(seq_t'(mode))));  // R3
endmodule

bind modctr_set modctr_set_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .cnt_en    (cnt_en),
    .mode      (mode),
    .count     (count),
    .term_cnt  (term_cnt),
    .carry_out (carry_out)
);

// File: tb/modctr_set_bench.sv
module modctr_set_bench;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       cnt_en = 1'b0;
    logic [1:0] mode = 2'd0;
    logic [3:0] count;
    logic       term_cnt;
    logic       carry_out;

    int n_chk = 0;
    int n_bad = 0;
    logic [3:0] exp_q = 4'd0;
    bit   done = 1'b0;

    always #2 clk = ~clk;

    modctr_set u_modctr_set (
        .clk       (clk),
        .rst       (rst),
        .cnt_en    (cnt_en),
        .mode      (mode),
        .count     (count),
        .term_cnt  (term_cnt),
        .carry_out (carry_out)
    );

    function automatic logic [3:0] first_of(input logic [1:0] m);
        return (m == 2'd2) ? 4'd9 : 4'd0;
    endfunction

    function automatic logic [3:0] last_of(input logic [1:0] m);
        case (m)
            2'd1:    return 4'd6;
            2'd2:    return 4'd14;
            default: return 4'd9;
        endcase
    endfunction

    task automatic chk(input string tag, input logic [3:0] act, input logic [3:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // One clock: apply inputs, check flags before the edge, then check count after it.
    task automatic cycle(input logic r, input logic e, input string tag);
        rst = r;
        cnt_en = e;
        #1;
        if (!r) begin
            chk({tag, " term"}, {3'b0, term_cnt},
                {3'b0, (e && exp_q == last_of(mode))});
            chk("R7 carry", {3'b0, carry_out}, 4'd0);
        end
        if (r)              exp_q = first_of(mode);
        else if (e)         exp_q = (exp_q == last_of(mode)) ? first_of(mode) : 4'(exp_q + 4'd1);
        @(posedge clk);
        #1;
        chk({tag, " count"}, count, exp_q);
    endtask

    task automatic t_reset(input logic [1:0] m);
        mode = m;
        cycle(1'b1, 1'b0, "R1");
        cycle(1'b1, 1'b0, "R1");
    endtask

    task automatic t_run(input logic [1:0] m, input int n, input string tag);
        t_reset(m);
        for (int k = 0; k < n; k++) cycle(1'b0, 1'b1, tag);
    endtask

    task automatic t_hold(input logic [1:0] m);
        t_reset(m);
        while (exp_q != last_of(m)) cycle(1'b0, 1'b1, "R5");
        for (int k = 0; k < 3; k++) cycle(1'b0, 1'b0, "R5");
        chk("R5 held at terminal", count, last_of(m));
        cycle(1'b0, 1'b1, "R5");
        cycle(1'b0, 1'b1, "R5");
        cycle(1'b0, 1'b0, "R5");
    endtask

    task automatic t_rst_prio(input logic [1:0] m);
        t_reset(m);
        cycle(1'b0, 1'b1, "R9");
        cycle(1'b0, 1'b1, "R9");
        cycle(1'b1, 1'b1, "R9");
        chk("R9 preset", count, first_of(m));
        while (exp_q != last_of(m)) cycle(1'b0, 1'b1, "R9");
        cycle(1'b1, 1'b1, "R9");
        chk("R9 preset at end", count, first_of(m));
    endtask

    initial begin
        @(posedge clk);
        #1;
        t_reset(2'd0);
        chk("R1 reset dec", count, 4'd0);
        t_run(2'd0, 32, "R2");
        t_run(2'd1, 23, "R3");
        t_run(2'd2, 20, "R4");
        t_reset(2'd2);
        chk("R1 reset ofs", count, 4'd9);
        t_run(2'd3, 31, "R8");
        t_hold(2'd0);
        t_hold(2'd1);
        t_hold(2'd2);
        t_run(2'd1, 8, "R6");
        t_rst_prio(2'd2);
        t_rst_prio(2'd0);
        if (!done) begin
            done = 1'b1;
            $display("test done: total=%0d bad=%0d", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        #(4 * 200000);
        if (!done) begin
            done = 1'b1;
            n_chk++;
            n_bad++;
            $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
            $display("test done: total=%0d bad=%0d", n_chk, n_bad);
            $finish;
        end
    end
endmodule